// File: doc/BRIEF.md
# Palette Framebuffer Control Registers

This block is the register slave of a palette-indexed framebuffer controller. A host issues 32-bit register reads and writes over a simple request bus. The block keeps the colour lookup table, the three cursor colours, the cursor bitmap, the cursor position, a control word, the scan-out start offset and the visible display size. The display size is stored in its scaled form: width is kept as four times the value written, and height as half the value written.

The pixel pipeline next to this block reads the three lookup stores through dedicated registered ports. It also takes the decoded pixel depth, blank, cursor-enable, size, start offset and cursor position straight from registered outputs. A frame-done pulse from the scan-out logic raises an interrupt, and any register write lowers it. One write address acts as a soft reset that clears all stored state. Writes to the video-timing addresses are accepted and have no effect. Any other address outside the map reports an error for one cycle.

Top module: `fbctl_regs`

## Requirements
- R1: After rst_n is held low for a clock, the following outputs read zero: width, height, start offset, cursor position, blank, irq_o, rsp_valid_o, rsp_err_o and all pixel read ports. depth_o reads 1 and cursor_en_o reads 1.
- R2: Colour table entry i is at byte address 0x800 + 8*i, for i from 0 to 255; any address in [0x800, 0x1000) selects entry (addr-0x800)>>3. Write data bits 23:16/15:8/7:0 are red/green/blue. A bus read returns the triple in the same bits with bits 31:24 zero. The pixel port returns entry clut_idx_i one clock after the index is presented.
- R3: The three cursor colours are at [0x508, 0x520), entry (addr-0x508)>>3. They use the same bit packing and are readable. cpal_idx_i values 0..2 return that entry one clock later; value 3 returns zero.
- R4: There are 512 cursor bitmap words of 16 bits at [0x1000, 0x2000), word (addr-0x1000)>>3. A write stores data bits 15:0. A read returns the word zero-extended. The pixel port cpat_idx_i has one clock of latency.
- R5: A write of d to 0x118 sets width_o to 4*d (truncated to DIM_W bits). A read of 0x118 returns width_o/4.
- R6: A write of d to 0x150 sets height_o to d/2, rounded down. A read of 0x150 returns 2*height_o.
- R7: The control word at 0x300 reads back as written. depth_o is taken from bits 22:20: codes 0..7 map to 1, 2, 4, 8, 15, 16, 0, 0. blank_o equals bit 10. cursor_en_o is the inverse of bit 23.
- R8: A write to 0x400 sets top_o and a write to 0x638 sets cursor_pos_o, each taking the low bits of the data. Reads of either address return zero with rsp_err_o set.
- R9: A write to 0x100000 clears both colour stores, the cursor bitmap, the cursor position, the control word, the start offset, width and height, and lowers irq_o.
- R10: Writes to 0x000, 0x108, 0x110, 0x120, 0x128, 0x130, 0x138, 0x140, 0x148, 0x158, 0x160, 0x168, 0x170 and 0x200 change no state and do not set rsp_err_o.
- R11: A read of an address that is not readable returns rdata zero with rsp_err_o high for one cycle. A write to an address that is not mapped changes no state and sets rsp_err_o for one cycle. Read responses appear one clock after the request, with rsp_valid_o high.
- R12: A frame_done_i pulse sets irq_o on the next clock. Any write clears irq_o on the next clock, and a write takes priority over a frame_done_i pulse in the same cycle. Reads leave irq_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Bus request strobe, one cycle per access |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (21) | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one clock after a read request |
| rsp_rdata_o | output | 32 | Read data |
| rsp_err_o | output | 1 | Access error pulse |
| frame_done_i | input | 1 | Frame completed pulse from scan-out |
| irq_o | output | 1 | Frame interrupt |
| depth_o | output | 5 | Decoded bits per pixel |
| blank_o | output | 1 | Forced blanking |
| cursor_en_o | output | 1 | Cursor overlay enabled |
| width_o | output | DIM_W (16) | Display width in pixels |
| height_o | output | DIM_W (16) | Display height in lines |
| top_o | output | TOP_W (23) | Scan-out start offset |
| cursor_pos_o | output | CPOS_W (24) | Cursor position word |
| clut_idx_i | input | 8 | Colour table pixel index |
| clut_rgb_o | output | 24 | Colour table pixel data |
| cpal_idx_i | input | 2 | Cursor colour pixel index |
| cpal_rgb_o | output | 24 | Cursor colour pixel data |
| cpat_idx_i | input | 9 | Cursor bitmap pixel index |
| cpat_word_o | output | 16 | Cursor bitmap pixel word |

## Verification
The hardest behaviour to reach from the ports is the soft reset. It has to be shown to clear every store at once, including table entries far from index 0 and the cursor bitmap. The stimulus therefore first fills the far ends of all three stores and every scalar register with non-zero values, and confirms they are set. It then issues the single reset write and reads those locations back through both the bus and the pixel ports. The write-over-frame priority of the interrupt needs a frame_done_i pulse in the same cycle as a write, so a dedicated task drives both strobes together.

// File: rtl/fbctl_pkg.sv
// Shared constants, region codes and the pixel-depth decode for the
// framebuffer control register block. Assumes byte addressing.
package fbctl_pkg;

    localparam int CLUT_DEPTH = 256;
    localparam int CPAL_DEPTH = 3;
    localparam int CPAT_DEPTH = 512;
    localparam int STRIDE     = 8;
    localparam int RGB_W      = 24;
    localparam int CPAT_W     = 16;
    localparam int DEPTH_W    = 5;

    localparam logic [31:0] CLUT_BASE = 32'h0000_0800;
    localparam logic [31:0] CPAL_BASE = 32'h0000_0508;
    localparam logic [31:0] CPAT_BASE = 32'h0000_1000;
    localparam logic [31:0] CLUT_SPAN = 32'(CLUT_DEPTH * STRIDE);
    localparam logic [31:0] CPAL_SPAN = 32'(CPAL_DEPTH * STRIDE);
    localparam logic [31:0] CPAT_SPAN = 32'(CPAT_DEPTH * STRIDE);

    localparam logic [31:0] A_HSIZE = 32'h0000_0118;
    localparam logic [31:0] A_VSIZE = 32'h0000_0150;
    localparam logic [31:0] A_CTL   = 32'h0000_0300;
    localparam logic [31:0] A_TOP   = 32'h0000_0400;
    localparam logic [31:0] A_CPOS  = 32'h0000_0638;
    localparam logic [31:0] A_SRST  = 32'h0010_0000;

    localparam int CTL_BLANK_BIT = 10;
    localparam int CTL_NOCUR_BIT = 23;
    localparam int CTL_DEPTH_LSB = 20;

    typedef enum logic [3:0] {
        RG_NONE, RG_CLUT, RG_CPAL, RG_CPAT, RG_HSIZE, RG_VSIZE,
        RG_CTL, RG_TOP, RG_CPOS, RG_SRST, RG_TIMING
    } region_e;

    // Map the 3-bit depth code to bits per pixel.
    function automatic logic [DEPTH_W-1:0] depth_of(input logic [2:0] code);
        case (code)
            3'd0:    return 5'd1;
            3'd1:    return 5'd2;
            3'd2:    return 5'd4;
            3'd3:    return 5'd8;
            3'd4:    return 5'd15;
            3'd5:    return 5'd16;
            default: return 5'd0;
        endcase
    endfunction

endpackage

// File: rtl/fbctl_decode.sv
// Address decoder: classifies a byte address into a register region and
// computes the entry index for the windowed stores (stride of 8 bytes).
// Purely combinational; assumes ADDR_W covers the soft-reset address.
module fbctl_decode
    import fbctl_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int IDX_W  = 9
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  idx
);

    logic [31:0] a32;
    assign a32 = 32'(addr);

    // Region and index selection.
    always_comb begin
        region = RG_NONE;
        idx    = '0;
        if (a32 >= CPAT_BASE && a32 < CPAT_BASE + CPAT_SPAN) begin
            region = RG_CPAT;
            idx    = IDX_W'((a32 - CPAT_BASE) >> 3);
        end else if (a32 >= CLUT_BASE && a32 < CLUT_BASE + CLUT_SPAN) begin
            region = RG_CLUT;
            idx    = IDX_W'((a32 - CLUT_BASE) >> 3);
        end else if (a32 >= CPAL_BASE && a32 < CPAL_BASE + CPAL_SPAN) begin
            region = RG_CPAL;
            idx    = IDX_W'((a32 - CPAL_BASE) >> 3);
        end else if (a32 == A_HSIZE) region = RG_HSIZE;
        else if (a32 == A_VSIZE) region = RG_VSIZE;
        else if (a32 == A_CTL)   region = RG_CTL;
        else if (a32 == A_TOP)   region = RG_TOP;
        else if (a32 == A_CPOS)  region = RG_CPOS;
        else if (a32 == A_SRST)  region = RG_SRST;
        else if (a32 inside {32'h000, 32'h108, 32'h110, 32'h120, 32'h128,
                             32'h130, 32'h138, 32'h140, 32'h148, 32'h158,
                             32'h160, 32'h168, 32'h170, 32'h200})
            region = RG_TIMING;
    end

endmodule

// File: rtl/fbctl_lut.sv
// Flop-based lookup store with one write port, a bulk clear, a
// combinational bus read port and a registered pixel read port.
// Out-of-range indices read zero and are never written.
module fbctl_lut #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 24,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [IDX_W-1:0] ra_bus,
    output logic [WIDTH-1:0] rd_bus,
    input  logic [IDX_W-1:0] ra_pix,
    output logic [WIDTH-1:0] rd_pix
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic             w_in_range;

    assign w_in_range = (32'(waddr) < DEPTH);

    // Storage: cleared by reset or soft reset, else written on we.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we && w_in_range) begin
            mem[waddr] <= wdata;
        end
    end

    // Bus read: combinational lookup for the register read mux.
    assign rd_bus = (32'(ra_bus) < DEPTH) ? mem[ra_bus] : '0;

    // Pixel read: one-clock registered lookup.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_pix <= '0;
        else        rd_pix <= (32'(ra_pix) < DEPTH) ? mem[ra_pix] : '0;
    end

    // R2 (also R3, R4): a write lands in the addressed entry.
    assert_lut_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && w_in_range && !clr) |=> (mem[$past(waddr)] == $past(wdata)));

    // R9: a clear leaves entry 0 at zero.
    assert_lut_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (mem[0] == '0));

endmodule

// File: rtl/fbctl_regs.sv
// Framebuffer control register slave. Decodes 32-bit register accesses,
// holds the palettes, cursor bitmap and scalar display registers, answers
// reads one clock later, and drives the frame interrupt. Assumes one
// access per request strobe; reset is synchronous and active low.
module fbctl_regs
    import fbctl_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DIM_W  = 16,
    parameter int TOP_W  = 23,
    parameter int CPOS_W = 24,
    localparam int CLUT_IW = $clog2(CLUT_DEPTH),
    localparam int CPAL_IW = $clog2(CPAL_DEPTH),
    localparam int CPAT_IW = $clog2(CPAT_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid_i,
    input  logic               req_write_i,
    input  logic [ADDR_W-1:0]  req_addr_i,
    input  logic [31:0]        req_wdata_i,
    output logic               rsp_valid_o,
    output logic [31:0]        rsp_rdata_o,
    output logic               rsp_err_o,
    input  logic               frame_done_i,
    output logic               irq_o,
    output logic [DEPTH_W-1:0] depth_o,
    output logic               blank_o,
    output logic               cursor_en_o,
    output logic [DIM_W-1:0]   width_o,
    output logic [DIM_W-1:0]   height_o,
    output logic [TOP_W-1:0]   top_o,
    output logic [CPOS_W-1:0]  cursor_pos_o,
    input  logic [CLUT_IW-1:0] clut_idx_i,
    output logic [RGB_W-1:0]   clut_rgb_o,
    input  logic [CPAL_IW-1:0] cpal_idx_i,
    output logic [RGB_W-1:0]   cpal_rgb_o,
    input  logic [CPAT_IW-1:0] cpat_idx_i,
    output logic [CPAT_W-1:0]  cpat_word_o
);

    region_e            region;
    logic [CPAT_IW-1:0] idx;
    logic               wr, rd, srst;
    logic [31:0]        ctl_q;
    logic [RGB_W-1:0]   clut_bus, cpal_bus;
    logic [CPAT_W-1:0]  cpat_bus;

    assign wr   = req_valid_i && req_write_i;
    assign rd   = req_valid_i && !req_write_i;
    assign srst = wr && (region == RG_SRST);

    fbctl_decode #(.ADDR_W(ADDR_W), .IDX_W(CPAT_IW)) u_dec (
        .addr(req_addr_i), .region(region), .idx(idx)
    );

    fbctl_lut #(.DEPTH(CLUT_DEPTH), .WIDTH(RGB_W)) u_clut (
        .clk(clk), .rst_n(rst_n), .clr(srst),
        .we(wr && region == RG_CLUT), .waddr(idx[CLUT_IW-1:0]),
        .wdata(req_wdata_i[RGB_W-1:0]), .ra_bus(idx[CLUT_IW-1:0]),
        .rd_bus(clut_bus), .ra_pix(clut_idx_i), .rd_pix(clut_rgb_o)
    );

    fbctl_lut #(.DEPTH(CPAL_DEPTH), .WIDTH(RGB_W)) u_cpal (
        .clk(clk), .rst_n(rst_n), .clr(srst),
        .we(wr && region == RG_CPAL), .waddr(idx[CPAL_IW-1:0]),
        .wdata(req_wdata_i[RGB_W-1:0]), .ra_bus(idx[CPAL_IW-1:0]),
        .rd_bus(cpal_bus), .ra_pix(cpal_idx_i), .rd_pix(cpal_rgb_o)
    );

    fbctl_lut #(.DEPTH(CPAT_DEPTH), .WIDTH(CPAT_W)) u_cpat (
        .clk(clk), .rst_n(rst_n), .clr(srst),
        .we(wr && region == RG_CPAT), .waddr(idx),
        .wdata(req_wdata_i[CPAT_W-1:0]), .ra_bus(idx),
        .rd_bus(cpat_bus), .ra_pix(cpat_idx_i), .rd_pix(cpat_word_o)
    );

    // Scalar registers: cleared by either reset, loaded by writes.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            ctl_q        <= '0;
            depth_o      <= depth_of(3'd0);
            width_o      <= '0;
            height_o     <= '0;
            top_o        <= '0;
            cursor_pos_o <= '0;
        end else if (wr) begin
            case (region)
                RG_HSIZE: width_o      <= DIM_W'({req_wdata_i, 2'b00});
                RG_VSIZE: height_o     <= DIM_W'(req_wdata_i >> 1);
                RG_CTL: begin
                    ctl_q   <= req_wdata_i;
                    depth_o <= depth_of(req_wdata_i[CTL_DEPTH_LSB +: 3]);
                end
                RG_TOP:   top_o        <= TOP_W'(req_wdata_i);
                RG_CPOS:  cursor_pos_o <= CPOS_W'(req_wdata_i);
                default: ;
            endcase
        end
    end

    assign blank_o     = ctl_q[CTL_BLANK_BIT];
    assign cursor_en_o = !ctl_q[CTL_NOCUR_BIT];

    // Read response and error pulse, one clock after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_o <= 1'b0;
            rsp_rdata_o <= '0;
            rsp_err_o   <= 1'b0;
        end else begin
            rsp_valid_o <= rd;
            rsp_rdata_o <= '0;
            rsp_err_o   <= wr && (region == RG_NONE);
            if (rd) begin
                case (region)
                    RG_CLUT:  rsp_rdata_o <= 32'(clut_bus);
                    RG_CPAL:  rsp_rdata_o <= 32'(cpal_bus);
                    RG_CPAT:  rsp_rdata_o <= 32'(cpat_bus);
                    RG_HSIZE: rsp_rdata_o <= 32'(width_o >> 2);
                    RG_VSIZE: rsp_rdata_o <= 32'({height_o, 1'b0});
                    RG_CTL:   rsp_rdata_o <= ctl_q;
                    default:  rsp_err_o   <= 1'b1;
                endcase
            end
        end
    end

    // Interrupt: writes clear with priority, frame pulses set.
    always_ff @(posedge clk) begin
        if (!rst_n)            irq_o <= 1'b0;
        else if (wr)           irq_o <= 1'b0;
        else if (frame_done_i) irq_o <= 1'b1;
    end

    assert_irq_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !irq_o);

    assert_irq_raise_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_i && !wr) |=> irq_o);

    assert_srst_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (width_o == '0 && height_o == '0 && top_o == '0 &&
                  cursor_pos_o == '0 && !blank_o && cursor_en_o));

    assert_timing_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && region == RG_TIMING) |=> ($stable(width_o) && $stable(height_o) &&
            $stable(top_o) && $stable(cursor_pos_o) && $stable(depth_o) && !rsp_err_o));

    assert_no_req_no_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!rsp_err_o && !rsp_valid_o));

    assert_width_scale_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && region == RG_HSIZE) |=> (width_o[1:0] == 2'b00));

    assert_depth_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o inside {5'd0, 5'd1, 5'd2, 5'd4, 5'd8, 5'd15, 5'd16});

endmodule

// File: tb/fbctl_regs_tb_top.sv
// Directed bench for fbctl_regs: one task per scenario, each checking
// its own results. Inputs change on the falling edge, outputs are
// sampled on the falling edge after the capturing rising edge.
module fbctl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0, req_write_i = 1'b0;
    logic [20:0] req_addr_i = '0;
    logic [31:0] req_wdata_i = '0;
    logic        rsp_valid_o, rsp_err_o, irq_o, blank_o, cursor_en_o;
    logic [31:0] rsp_rdata_o;
    logic        frame_done_i = 1'b0;
    logic [4:0]  depth_o;
    logic [15:0] width_o, height_o;
    logic [22:0] top_o;
    logic [23:0] cursor_pos_o;
    logic [7:0]  clut_idx_i = '0;
    logic [23:0] clut_rgb_o, cpal_rgb_o;
    logic [1:0]  cpal_idx_i = '0;
    logic [8:0]  cpat_idx_i = '0;
    logic [15:0] cpat_word_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fbctl_regs dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i),
        .req_write_i(req_write_i), .req_addr_i(req_addr_i),
        .req_wdata_i(req_wdata_i), .rsp_valid_o(rsp_valid_o),
        .rsp_rdata_o(rsp_rdata_o), .rsp_err_o(rsp_err_o),
        .frame_done_i(frame_done_i), .irq_o(irq_o), .depth_o(depth_o),
        .blank_o(blank_o), .cursor_en_o(cursor_en_o), .width_o(width_o),
        .height_o(height_o), .top_o(top_o), .cursor_pos_o(cursor_pos_o),
        .clut_idx_i(clut_idx_i), .clut_rgb_o(clut_rgb_o),
        .cpal_idx_i(cpal_idx_i), .cpal_rgb_o(cpal_rgb_o),
        .cpat_idx_i(cpat_idx_i), .cpat_word_o(cpat_word_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d, output logic err);
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = 1'b1;
        req_addr_i = a[20:0]; req_wdata_i = d;
        @(negedge clk);
        err = rsp_err_o;
        req_valid_i = 1'b0; req_write_i = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d, output logic err);
        @(negedge clk);
        req_valid_i = 1'b1; req_write_i = 1'b0; req_addr_i = a[20:0];
        @(negedge clk);
        d = rsp_rdata_o; err = rsp_err_o;
        check("R11 rsp_valid", 32'(rsp_valid_o), 32'd1);
        req_valid_i = 1'b0;
    endtask

    task automatic pix_read(input logic [7:0] ci, input logic [1:0] pi, input logic [8:0] ti);
        @(negedge clk);
        clut_idx_i = ci; cpal_idx_i = pi; cpat_idx_i = ti;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 width", 32'(width_o), 0);
        check("R1 height", 32'(height_o), 0);
        check("R1 top", 32'(top_o), 0);
        check("R1 cpos", 32'(cursor_pos_o), 0);
        check("R1 depth", 32'(depth_o), 1);
        check("R1 blank/cursor_en", {30'd0, blank_o, cursor_en_o}, 32'd1);
        check("R1 irq/valid/err", {29'd0, irq_o, rsp_valid_o, rsp_err_o}, 0);
        check("R1 pixel ports", 32'(clut_rgb_o | cpal_rgb_o | 24'(cpat_word_o)), 0);
    endtask

    task automatic t_clut();
        logic e; logic [31:0] d;
        bus_write(32'h800, 32'hAB12_3456, e);
        bus_write(32'hFF8, 32'h0001_0203, e);
        bus_read(32'h800, d, e);
        check("R2 entry0 read drops 31:24", d, 32'h0012_3456);
        bus_read(32'hFFC, d, e);
        check("R2 entry255 via offset+4", d, 32'h0001_0203);
        check("R2 read err", 32'(e), 0);
        pix_read(8'd255, 2'd0, 9'd0);
        check("R2 pixel 255", 32'(clut_rgb_o), 32'h01_0203);
        pix_read(8'd0, 2'd0, 9'd0);
        check("R2 pixel 0", 32'(clut_rgb_o), 32'h12_3456);
    endtask

    task automatic t_cpal();
        logic e; logic [31:0] d;
        bus_write(32'h508, 32'h0011_2233, e);
        bus_write(32'h510, 32'h0044_5566, e);
        bus_write(32'h518, 32'hFF77_8899, e);
        bus_read(32'h514, d, e);
        check("R3 entry1 read", d, 32'h0044_5566);
        pix_read(8'd0, 2'd2, 9'd0);
        check("R3 pixel 2", 32'(cpal_rgb_o), 32'h77_8899);
        pix_read(8'd0, 2'd3, 9'd0);
        check("R3 pixel 3 zero", 32'(cpal_rgb_o), 0);
        bus_read(32'h520, d, e);
        check("R11 past cursor colours err", {d[30:0], e}, 32'd1);
    endtask

    task automatic t_cpat();
        logic e; logic [31:0] d;
        bus_write(32'h1000, 32'hDEAD_BEEF, e);
        bus_write(32'h1FF8, 32'h0000_1234, e);
        bus_read(32'h1000, d, e);
        check("R4 word0 low 16", d, 32'h0000_BEEF);
        bus_read(32'h1FF8, d, e);
        check("R4 word511", d, 32'h0000_1234);
        pix_read(8'd0, 2'd0, 9'd511);
        check("R4 pixel 511", 32'(cpat_word_o), 32'h1234);
    endtask

    task automatic t_dims();
        logic e; logic [31:0] d;
        bus_write(32'h118, 32'd160, e);
        check("R5 width x4", 32'(width_o), 640);
        bus_read(32'h118, d, e);
        check("R5 width readback", d, 160);
        bus_write(32'h150, 32'd961, e);
        check("R6 height /2", 32'(height_o), 480);
        bus_read(32'h150, d, e);
        check("R6 height readback", d, 960);
    endtask

    task automatic t_ctl();
        logic e; logic [31:0] d;
        bus_write(32'h300, 32'h0030_0400, e);
        check("R7 code3 depth", 32'(depth_o), 8);
        check("R7 blank on cursor on", {30'd0, blank_o, cursor_en_o}, 32'd3);
        bus_read(32'h300, d, e);
        check("R7 readback", d, 32'h0030_0400);
        bus_write(32'h300, 32'h0080_0000 | (32'd4 << 20), e);
        check("R7 code4 depth", 32'(depth_o), 15);
        check("R7 cursor off", {30'd0, blank_o, cursor_en_o}, 0);
        bus_write(32'h300, 32'd5 << 20, e);
        check("R7 code5 depth", 32'(depth_o), 16);
        bus_write(32'h300, 32'd6 << 20, e);
        check("R7 code6 depth", 32'(depth_o), 0);
        bus_write(32'h300, 32'd1 << 20, e);
        check("R7 code1 depth", 32'(depth_o), 2);
    endtask

    task automatic t_pos();
        logic e; logic [31:0] d;
        bus_write(32'h400, 32'h0001_2000, e);
        check("R8 top", 32'(top_o), 32'h1_2000);
        bus_write(32'h638, 32'h0006_4032, e);
        check("R8 cursor pos", 32'(cursor_pos_o), 32'h06_4032);
        bus_read(32'h400, d, e);
        check("R8 top unreadable", {d[30:0], e}, 32'd1);
        bus_read(32'h638, d, e);
        check("R8 cpos unreadable", {d[30:0], e}, 32'd1);
    endtask

    task automatic t_timing();
        logic e; logic [31:0] d;
        logic [31:0] tad [14] = '{32'h000, 32'h108, 32'h110, 32'h120, 32'h128,
            32'h130, 32'h138, 32'h140, 32'h148, 32'h158, 32'h160, 32'h168,
            32'h170, 32'h200};
        for (int k = 0; k < 14; k++) begin
            bus_write(tad[k], 32'hFFFF_FFFF, e);
            check("R10 timing write no err", 32'(e), 0);
        end
        check("R10 width kept", 32'(width_o), 640);
        check("R10 height kept", 32'(height_o), 480);
        check("R10 top kept", 32'(top_o), 32'h1_2000);
        bus_read(32'h300, d, e);
        check("R10 ctl kept", d, 32'd1 << 20);
    endtask

    task automatic t_unmapped();
        logic e; logic [31:0] d;
        bus_read(32'h004, d, e);
        check("R11 read unmapped data", d, 0);
        check("R11 read unmapped err", 32'(e), 1);
        bus_write(32'h700, 32'h1234_5678, e);
        check("R11 write unmapped err", 32'(e), 1);
        @(negedge clk);
        check("R11 err one cycle", 32'(rsp_err_o), 0);
        check("R11 state kept", 32'(width_o), 640);
    endtask

    task automatic t_irq();
        logic e; logic [31:0] d;
        @(negedge clk); frame_done_i = 1'b1;
        @(negedge clk); frame_done_i = 1'b0;
        check("R12 frame sets irq", 32'(irq_o), 1);
        bus_read(32'h300, d, e);
        check("R12 read keeps irq", 32'(irq_o), 1);
        bus_write(32'h108, 32'h0, e);
        check("R12 write clears irq", 32'(irq_o), 0);
        @(negedge clk); frame_done_i = 1'b1;
        req_valid_i = 1'b1; req_write_i = 1'b1; req_addr_i = 21'h110;
        @(negedge clk); frame_done_i = 1'b0; req_valid_i = 1'b0; req_write_i = 1'b0;
        check("R12 write beats frame", 32'(irq_o), 0);
        @(negedge clk); frame_done_i = 1'b1;
        @(negedge clk); frame_done_i = 1'b0;
    endtask

    task automatic t_srst();
        logic e; logic [31:0] d;
        bus_write(32'h300, 32'h0000_0400, e);
        check("R9 pre irq", 32'(irq_o), 0);
        @(negedge clk); frame_done_i = 1'b1;
        @(negedge clk); frame_done_i = 1'b0;
        bus_write(32'h100000, 32'h0, e);
        check("R9 irq lowered", 32'(irq_o), 0);
        check("R9 width", 32'(width_o), 0);
        check("R9 height", 32'(height_o), 0);
        check("R9 top", 32'(top_o), 0);
        check("R9 cpos", 32'(cursor_pos_o), 0);
        check("R9 depth/blank", {26'd0, depth_o, blank_o}, 32'd2);
        bus_read(32'hFF8, d, e);
        check("R9 clut 255", d, 0);
        bus_read(32'h1000, d, e);
        check("R9 cpat 0", d, 0);
        bus_read(32'h300, d, e);
        check("R9 ctl", d, 0);
        pix_read(8'd0, 2'd2, 9'd511);
        check("R9 pixel ports", 32'(clut_rgb_o | cpal_rgb_o | 24'(cpat_word_o)), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clut();
        t_cpal();
        t_cpat();
        t_dims();
        t_ctl();
        t_pos();
        t_timing();
        t_unmapped();
        t_irq();
        t_srst();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule